// File: doc/BRIEF.md
# Double-Buffered Serial Configuration Port

This block is the programming front end of a frequency synthesizer. A host drives a serial data line and a slow serial clock, plus a few level strobes that pick where the bits go. Each rising serial-clock edge shifts one bit into one of three shift registers. The first is a 20-bit working frequency word. The second is a 20-bit image of the non-volatile settings. The third is an 8-bit enhancement register. Bits arrive least-significant first.

The divider does not see the working word directly. A rising edge on the transfer strobe copies the whole working word into a 20-bit holding register, and the holding register drives the divider. The host can therefore rewrite the working word freely without disturbing the synthesizer.

The image register can be read back one bit per serial clock on a serial data output. A one-cycle recall input copies the image into the working word, which models restoring stored settings at power-up. The enhancement bits reach their outputs only while an active-low gate input is held low.

All serial pins are asynchronous to the block clock. They are synchronized and edge-detected inside the block, so the block needs only one clock.

Top module: `synth_cfg_port`

## Requirements
- R1: Each rising serial-clock edge shifts one bit, least-significant bit first, into the selected 20-bit register. The bit enters at bit 19 and moves toward bit 0, so after more than 20 shifts only the last 20 bits remain. The effect is visible within 5 block-clock cycles of the pin edge.
- R2: The target is chosen at each rising serial-clock edge. With enhancement-write high, the bit goes to the enhancement register. With enhancement-write low and image-select high, it goes to the image register. With both low, it goes to the working word. The registers that are not targeted keep their contents.
- R3: A rising edge of the synchronized transfer strobe copies the working word into the holding register that drives `div_word_o`. At no other time does `div_word_o` change, including while the strobe stays high.
- R4: The 8-bit enhancement register shifts least-significant bit first, the same way as R1.
- R5: `enh_o` equals the enhancement register while `enh_gate_n_i` is low and is all zeros while it is high. The register contents survive the gating.
- R6: The 20-bit image register shifts in least-significant bit first. On each falling serial-clock edge, `sdata_o` takes the image register's bit 0, and it holds that value between falling edges. Clocking the image 20 times while feeding its own bits back returns it unchanged, and the output shows the original bits 1, 2, …, 19, 0 in that order.
- R7: A one-cycle high on `recall_i` copies the image register into the working word on the next block-clock edge. The recall wins over a serial shift into the working word in the same cycle.
- R8: While `rst_n` is low at a block-clock edge, every register clears, so `div_word_o`, `enh_o` and `sdata_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, least-significant bit first |
| xfer_i | input | 1 | Transfer strobe; a rising edge copies the working word to the holding register |
| enh_wr_i | input | 1 | High: serial bits go to the enhancement register |
| img_sel_i | input | 1 | High (with enh_wr_i low): serial bits go to the image register |
| enh_gate_n_i | input | 1 | Active-low enable of the enhancement outputs |
| recall_i | input | 1 | Synchronous one-cycle image-to-working-word copy |
| sdata_o | output | 1 | Serial readback of image bit 0, updated on falling serial-clock edges |
| div_word_o | output | 20 | Holding register driving the divider |
| enh_o | output | 8 | Gated enhancement bits |

## Verification
The embedded assertions check the local steps on every cycle:
- each single shift step of every shift register and its hold when idle;
- the copy into the holding register on a transfer edge, and its hold at all other times;
- the stability of the readback output between falling edges;
- the recall copy.

The scenarios in the testbench cover what no single-cycle property can show:
- whole words arriving least-significant bit first and the truncation of over-long words;
- routing by the strobes, with the untargeted registers left intact;
- the transfer strobe held high;
- enhancement gating that preserves the register;
- a full 20-bit readback rotation;
- a reset in the middle of a run.

// File: rtl/scp_pkg.sv
// Shared widths, synchronizer bit positions and the shift-target decode
// for the serial configuration port.
package scp_pkg;
    localparam int FREQ_W = 20;
    localparam int ENH_W  = 8;

    // Bit positions inside the synchronizer bundle
    localparam int SYN_SCLK   = 0;
    localparam int SYN_SDATA  = 1;
    localparam int SYN_XFER   = 2;
    localparam int SYN_IMGSEL = 3;
    localparam int SYN_ENHWR  = 4;
    localparam int SYN_W      = 5;

    typedef enum logic [1:0] {
        TGT_PRIMARY = 2'd0,
        TGT_IMAGE   = 2'd1,
        TGT_ENHANCE = 2'd2
    } tgt_e;

    // Enhancement write has priority; otherwise image select picks the image.
    function automatic tgt_e pick_target(input logic enh_wr, input logic img_sel);
        if (enh_wr)       return TGT_ENHANCE;
        else if (img_sel) return TGT_IMAGE;
        else              return TGT_PRIMARY;
    endfunction
endpackage

// File: rtl/scp_sync.sv
// Multi-stage level synchronizer for a bundle of asynchronous pins.
// Assumes each pin is stable for several clock cycles between changes.
// Every bit gets the same latency, so the bits stay aligned with one another.
module scp_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            logic [STAGES-1:0] chain_q;
            // Move the pin level through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
            end
            assign sync_o[b] = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/scp_edge.sv
// Single-cycle edge pulse from a synchronized level.
// RISING selects which edge is detected (1 = rising, 0 = falling).
module scp_edge #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic edge_o
);
    logic prev_q;

    // Remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end

    generate
        if (RISING) begin : g_rise
            assign edge_o = lvl_i & ~prev_q;
        end else begin : g_fall
            assign edge_o = ~lvl_i & prev_q;
        end
    endgenerate
endmodule

// File: rtl/scp_route.sv
// Turns one serial shift strobe into a shift enable for exactly one of
// the three registers, following the priority set by the control strobes.
// Assumes that the strobes are already synchronized and aligned with the strobe.
module scp_route
    import scp_pkg::*;
(
    input  logic shift_i,
    input  logic enh_wr_i,
    input  logic img_sel_i,
    output logic en_pri_o,
    output logic en_img_o,
    output logic en_enh_o
);
    tgt_e tgt;

    // Decode the target and gate it with the shift strobe.
    always_comb begin
        tgt      = pick_target(enh_wr_i, img_sel_i);
        en_pri_o = 1'b0;
        en_img_o = 1'b0;
        en_enh_o = 1'b0;
        unique case (tgt)
            TGT_ENHANCE: en_enh_o = shift_i;
            TGT_IMAGE:   en_img_o = shift_i;
            default:     en_pri_o = shift_i;
        endcase
    end
endmodule

// File: rtl/scp_shreg.sv
// Right-shifting register with a parallel load. The serial bit enters at the
// MSB, so a word sent LSB first lines up with bit 0 after W shifts.
// The parallel load wins over a shift in the same cycle.
module scp_shreg #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         shift_i,
    input  logic         sin_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;

    // Load, shift or hold the register.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (load_i)  q <= load_val_i;
        else if (shift_i) q <= {sin_i, q[W-1:1]};
    end

    assign q_o = q;

    // R1
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i) |=> (q == {$past(sin_i), $past(q[W-1:1])}));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_i && !load_i) |=> $stable(q));
endmodule

// File: rtl/synth_cfg_port.sv
// Serial configuration port of a frequency synthesizer.
// The port samples the serial pins through synchronizers in the block-clock
// domain. It shifts bits into the working, image or enhancement register,
// and on a transfer edge it copies the working word into the holding
// register that drives the divider. It reads the image back on a falling
// serial-clock edge. Assumes that each serial-clock phase lasts at least
// five block-clock cycles.
module synth_cfg_port
    import scp_pkg::*;
#(
    parameter int FW        = FREQ_W,
    parameter int EW        = ENH_W,
    parameter int SYNC_STGS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_i,
    input  logic          sdata_i,
    input  logic          xfer_i,
    input  logic          enh_wr_i,
    input  logic          img_sel_i,
    input  logic          enh_gate_n_i,
    input  logic          recall_i,
    output logic          sdata_o,
    output logic [FW-1:0] div_word_o,
    output logic [EW-1:0] enh_o
);
    logic [SYN_W-1:0] pins, syn;
    logic sclk_rise, sclk_fall, xfer_rise;
    logic en_pri, en_img, en_enh;
    logic [FW-1:0] pri_q, img_q, hold_q;
    logic [EW-1:0] enh_q;
    logic dout_q;

    assign pins = {enh_wr_i, img_sel_i, xfer_i, sdata_i, sclk_i};

    scp_sync #(.W(SYN_W), .STAGES(SYNC_STGS)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pins), .sync_o(syn));

    scp_edge #(.RISING(1'b1)) u_sclk_rise (
        .clk(clk), .rst_n(rst_n), .lvl_i(syn[SYN_SCLK]), .edge_o(sclk_rise));
    scp_edge #(.RISING(1'b0)) u_sclk_fall (
        .clk(clk), .rst_n(rst_n), .lvl_i(syn[SYN_SCLK]), .edge_o(sclk_fall));
    scp_edge #(.RISING(1'b1)) u_xfer_rise (
        .clk(clk), .rst_n(rst_n), .lvl_i(syn[SYN_XFER]), .edge_o(xfer_rise));

    scp_route u_route (
        .shift_i(sclk_rise), .enh_wr_i(syn[SYN_ENHWR]), .img_sel_i(syn[SYN_IMGSEL]),
        .en_pri_o(en_pri), .en_img_o(en_img), .en_enh_o(en_enh));

    scp_shreg #(.W(FW)) u_primary (
        .clk(clk), .rst_n(rst_n), .load_i(recall_i), .load_val_i(img_q),
        .shift_i(en_pri), .sin_i(syn[SYN_SDATA]), .q_o(pri_q));

    scp_shreg #(.W(FW)) u_image (
        .clk(clk), .rst_n(rst_n), .load_i(1'b0), .load_val_i('0),
        .shift_i(en_img), .sin_i(syn[SYN_SDATA]), .q_o(img_q));

    scp_shreg #(.W(EW)) u_enhance (
        .clk(clk), .rst_n(rst_n), .load_i(1'b0), .load_val_i('0),
        .shift_i(en_enh), .sin_i(syn[SYN_SDATA]), .q_o(enh_q));

    // Copy the working word into the holding register on a transfer edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         hold_q <= '0;
        else if (xfer_rise) hold_q <= pri_q;
    end

    // Present image bit 0 on the readback pin at each falling serial edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         dout_q <= 1'b0;
        else if (sclk_fall) dout_q <= img_q[0];
    end

    assign div_word_o = hold_q;
    assign sdata_o    = dout_q;
    assign enh_o      = enh_gate_n_i ? '0 : enh_q;

    // R3
    xfer_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_rise |=> (div_word_o == $past(pri_q)));

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_rise |=> $stable(div_word_o));

    // R6
    dout_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_fall |=> $stable(sdata_o));

    // R7
    recall_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recall_i |=> (pri_q == $past(img_q)));
endmodule

// File: tb/synth_cfg_port_tb.sv
// Scoreboard bench: the driver tasks push expected items, and a monitor pops and compares them.
module synth_cfg_port_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdata = 1'b0, xfer = 1'b0, enh_wr = 1'b0, img_sel = 1'b0;
    logic enh_gate_n = 1'b1, recall = 1'b0;
    logic sdata_o;
    logic [19:0] div_word;
    logic [7:0]  enh;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int          q_kind[$];
    logic [19:0] q_val[$];
    string       q_tag[$];

    always #2.5 clk = ~clk;

    synth_cfg_port u_dut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(sdata), .xfer_i(xfer),
        .enh_wr_i(enh_wr), .img_sel_i(img_sel), .enh_gate_n_i(enh_gate_n),
        .recall_i(recall), .sdata_o(sdata_o), .div_word_o(div_word), .enh_o(enh));

    // Monitor: pop each expected item and compare it with the matching output.
    initial begin
        forever begin
            @(negedge clk);
            if (q_kind.size() != 0) begin
                logic [19:0] act;
                repeat (2) @(negedge clk);
                case (q_kind[0])
                    0:       act = div_word;
                    1:       act = {12'd0, enh};
                    default: act = {19'd0, sdata_o};
                endcase
                checks++;
                if (act !== q_val[0]) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", q_tag[0], act, q_val[0]);
                end
                void'(q_kind.pop_front());
                void'(q_val.pop_front());
                void'(q_tag.pop_front());
            end
        end
    end

    task automatic expect_item(input int kind, input logic [19:0] val, input string tag);
        q_kind.push_back(kind);
        q_val.push_back(val);
        q_tag.push_back(tag);
        while (q_kind.size() != 0) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sclk_pulse(input logic b);
        sdata = b;
        idle(6);
        sclk = 1'b1;
        idle(6);
        sclk = 1'b0;
        idle(6);
    endtask

    task automatic send(input logic [31:0] v, input int n);
        for (int i = 0; i < n; i++) sclk_pulse(v[i]);
    endtask

    task automatic xfer_pulse();
        xfer = 1'b1;
        idle(8);
        xfer = 1'b0;
        idle(8);
    endtask

    localparam logic [19:0] IMG = 20'h5A3C1;

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        // R8 reset state
        expect_item(0, 20'h0, "R8 div after reset");
        expect_item(1, 20'h0, "R8 enh after reset");
        expect_item(2, 20'h0, "R8 dout after reset");

        // R1 R3 primary load and transfer
        send(32'hABCDE, 20);
        expect_item(0, 20'h0, "R3 div holds before transfer");
        xfer_pulse();
        expect_item(0, 20'hABCDE, "R1 R3 word after transfer");
        send(32'h12345, 20);
        expect_item(0, 20'hABCDE, "R3 shadow not visible");
        xfer_pulse();
        expect_item(0, 20'h12345, "R3 second transfer");

        // R4 R5 enhancement write and gating
        enh_wr = 1'b1;
        send(32'hA5, 8);
        enh_wr = 1'b0;
        enh_gate_n = 1'b0;
        idle(2);
        expect_item(1, 20'hA5, "R4 enh value");
        enh_gate_n = 1'b1;
        idle(2);
        expect_item(1, 20'h0, "R5 enh gated off");
        enh_gate_n = 1'b0;
        idle(2);
        expect_item(1, 20'hA5, "R5 enh kept under gate");
        xfer_pulse();
        expect_item(0, 20'h12345, "R2 primary untouched by enh write");

        // R6 image write and readback rotation
        img_sel = 1'b1;
        send({12'd0, IMG}, 20);
        expect_item(2, {19'd0, IMG[0]}, "R6 dout bit0 after image write");
        for (int k = 1; k <= 20; k++) begin
            sclk_pulse(IMG[k-1]);
            expect_item(2, {19'd0, IMG[k % 20]}, $sformatf("R6 readback bit %0d", k % 20));
        end
        img_sel = 1'b0;
        xfer_pulse();
        expect_item(0, 20'h12345, "R2 primary untouched by image write");
        enh_gate_n = 1'b0;
        idle(2);
        expect_item(1, 20'hA5, "R2 enh untouched by image write");

        // R7 recall copies the rotated-back image into the primary
        @(negedge clk);
        recall = 1'b1;
        @(negedge clk);
        recall = 1'b0;
        xfer_pulse();
        expect_item(0, IMG, "R7 recall then transfer");

        // R1 over-long word keeps the last 20 bits
        send(32'h9ABCDE, 24);
        xfer_pulse();
        expect_item(0, 20'h9ABCD, "R1 24-bit word truncated");

        // R3 transfer held high: no copy until the next rising edge
        xfer = 1'b1;
        idle(8);
        send(32'h0F0F0, 20);
        expect_item(0, 20'h9ABCD, "R3 held strobe no copy");
        xfer = 1'b0;
        idle(8);
        xfer_pulse();
        expect_item(0, 20'h0F0F0, "R3 copy on next edge");

        // R8 reset in the middle of a run
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        expect_item(0, 20'h0, "R8 div after mid reset");
        expect_item(1, 20'h0, "R8 enh after mid reset");
        expect_item(2, 20'h0, "R8 dout after mid reset");

        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(negedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule